// File: doc/BRIEF.md
# Serial configuration memory read path

This block is the read side of a write-once serial configuration memory. A byte-wide bit array, filled through a small programming port, is streamed out one bit at a time on a single data line. An external reader supplies the clock. It samples the data line on each rising edge, and that same edge moves the memory on to the next bit. The data line is modelled as a value plus an output-enable, which stands in for a tristate pin.

Two control pins gate the stream. An active-low chip enable freezes the position, releases the data line and raises a standby flag when it is High. A single combined pin acts as both counter reset and output enable. Its reset polarity is fixed at build time. While that pin is in its reset state, the position is cleared to the first bit and the data line is released. When reset is never applied, the position survives between read sessions, so several bitstreams can be stored one after another and read in turn. Within each byte, bits leave most-significant first. At the final bit the position stops and an end flag is raised.

Top module: `serprom_read`

## Requirements
- R1: A rising clock edge with the reset/enable pin in its reset state sets the position to bit 0 of byte 0. The reset takes priority over chip enable. After reset is released, the first bit of byte 0 is on the data line before any further edge, and the end flag is low.
- R2: While chip enable is Low and reset is inactive, each rising clock edge advances the position by exactly one bit. The new bit appears on the data line after that edge, so the reader samples it on the next edge.
- R3: Bit position k in byte a is output as bit (7 - k) of the stored byte a, so bits go out MSB first. After bit position 7 the position moves on to bit 0 of byte a+1.
- R4: While chip enable is High, the position does not change, data_en is 0 and standby is 1. While chip enable is Low, standby is 0.
- R5: data_en is 1 exactly when chip enable is Low and the reset/enable pin is in its non-reset state.
- R6: With RESET_HIGH=1, a High level on the reset/enable pin is the reset state. With RESET_HIGH=0, a Low level is the reset state and a High level enables the output.
- R7: Deasserting and then reasserting chip enable without a reset continues the stream at the bit that follows the last bit delivered.
- R8: At the last bit of the array (position DEPTH_BITS-1), end_flag is 1. Further enabled edges leave the position there, and the last bit stays on the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock from the reader; rising edge advances |
| ce_n | input | 1 | Chip enable, active Low |
| rst_oe | input | 1 | Combined counter reset / output enable; polarity set by RESET_HIGH |
| prog_we | input | 1 | Programming write strobe, one byte per clock |
| prog_addr | input | $clog2(DEPTH_BITS/8) | Programming byte address |
| prog_byte | input | 8 | Programming byte value |
| data_out | output | 1 | Serial data bit |
| data_en | output | 1 | Data line driven (1) or high-impedance (0) |
| standby | output | 1 | Low-power standby indication |
| end_flag | output | 1 | Position is at the last bit of the array |

## Verification
The bench checks the first bit right after reset is released. A design that registered the data one cycle late, or skipped bit 0, would show a shifted stream from that point on. It pauses chip enable in the middle of a byte and checks that the stream continues at the next bit. A design that advanced or reset while disabled would lose or repeat bits. The bench runs past the final bit, which catches a design that wraps to bit 0 or stops one bit early. It also drives reset together with a disabled chip enable, and it exercises the inverted-polarity build, where a swapped pin decode would drive the line while it is held in reset.

// File: rtl/prom_pkg.sv
`timescale 1ns/1ps
package prom_pkg;

    localparam int BYTE_BITS = 8;
    localparam int LANE_W    = $clog2(BYTE_BITS);

    // decoded view of the two control pins
    typedef struct packed {
        logic hold_zero;  // counter forced to the first bit
        logic advance;    // counter moves on at this edge
        logic drive;      // data line driven
        logic standby;    // low-power indication
    } pin_ctl_t;

    typedef enum logic [1:0] {
        PIN_RESET   = 2'd0,
        PIN_STANDBY = 2'd1,
        PIN_READ    = 2'd2
    } pin_mode_e;

    // lane k of a byte leaves as bit (7-k): most significant first
    function automatic logic msb_first_bit(input logic [BYTE_BITS-1:0] b,
                                           input logic [LANE_W-1:0] lane);
        return b[LANE_W'(BYTE_BITS-1) - lane];
    endfunction

endpackage

// File: rtl/prom_pin_decode.sv
`timescale 1ns/1ps
module prom_pin_decode
    import prom_pkg::*;
#(
    parameter bit RESET_HIGH = 1'b1
) (
    input  logic     ce_n,
    input  logic     rst_oe,
    output pin_ctl_t ctl
);

    logic      reset_level;
    pin_mode_e mode;

    assign reset_level = RESET_HIGH ? rst_oe : ~rst_oe;

    // reset wins over chip enable
    always_comb begin
        if (reset_level)   mode = PIN_RESET;
        else if (ce_n)     mode = PIN_STANDBY;
        else               mode = PIN_READ;
    end

    always_comb begin
        ctl.hold_zero = (mode == PIN_RESET);
        ctl.advance   = (mode == PIN_READ);
        ctl.drive     = (mode == PIN_READ);
        ctl.standby   = ce_n;
    end

endmodule

// File: rtl/prom_bit_counter.sv
`timescale 1ns/1ps
module prom_bit_counter
    import prom_pkg::*;
#(
    parameter int BYTES = 512,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              hold_zero,
    input  logic              advance,
    output logic [AW-1:0]     byte_addr,
    output logic [LANE_W-1:0] lane,
    output logic              at_last
);

    localparam logic [AW-1:0]     LAST_BYTE = AW'(BYTES - 1);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTE_BITS - 1);

    assign at_last = (byte_addr == LAST_BYTE) && (lane == LAST_LANE);

    always_ff @(posedge clk) begin
        if (hold_zero) begin
            byte_addr <= '0;
            lane      <= '0;
        end else if (advance && !at_last) begin
            if (lane == LAST_LANE) begin
                lane      <= '0;
                byte_addr <= byte_addr + 1'b1;
            end else begin
                lane <= lane + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prom_array.sv
`timescale 1ns/1ps
module prom_array
    import prom_pkg::*;
#(
    parameter int BYTES = 512,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [BYTE_BITS-1:0] wbyte,
    input  logic [AW-1:0]        raddr,
    output logic [BYTE_BITS-1:0] rbyte
);

    logic [BYTE_BITS-1:0] cells [BYTES];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wbyte;
    end

    assign rbyte = cells[raddr];

endmodule

// File: rtl/serprom_read.sv
`timescale 1ns/1ps
module serprom_read
    import prom_pkg::*;
#(
    parameter int DEPTH_BITS = 4096,
    parameter bit RESET_HIGH = 1'b1,
    localparam int BYTES     = DEPTH_BITS / BYTE_BITS,
    localparam int AW        = $clog2(BYTES)
) (
    input  logic                 clk,
    input  logic                 ce_n,
    input  logic                 rst_oe,
    input  logic                 prog_we,
    input  logic [AW-1:0]        prog_addr,
    input  logic [BYTE_BITS-1:0] prog_byte,
    output logic                 data_out,
    output logic                 data_en,
    output logic                 standby,
    output logic                 end_flag
);

    pin_ctl_t             ctl;
    logic [AW-1:0]        rd_byte;
    logic [LANE_W-1:0]    rd_lane;
    logic [BYTE_BITS-1:0] cur_byte;

    prom_pin_decode #(.RESET_HIGH(RESET_HIGH)) u_pins (
        .ce_n   (ce_n),
        .rst_oe (rst_oe),
        .ctl    (ctl)
    );

    prom_bit_counter #(.BYTES(BYTES)) u_count (
        .clk       (clk),
        .hold_zero (ctl.hold_zero),
        .advance   (ctl.advance),
        .byte_addr (rd_byte),
        .lane      (rd_lane),
        .at_last   (end_flag)
    );

    prom_array #(.BYTES(BYTES)) u_mem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wbyte (prog_byte),
        .raddr (rd_byte),
        .rbyte (cur_byte)
    );

    assign data_out = msb_first_bit(cur_byte, rd_lane);
    assign data_en  = ctl.drive;
    assign standby  = ctl.standby;

endmodule

// File: rtl/serprom_read_chk.sv
`timescale 1ns/1ps
module serprom_read_chk #(
    parameter bit RESET_HIGH = 1'b1
) (
    input logic clk,
    input logic ce_n,
    input logic rst_oe,
    input logic prog_we,
    input logic data_out,
    input logic data_en,
    input logic standby,
    input logic end_flag
);

    logic rst_act;
    logic seen = 1'b0;

    assign rst_act = RESET_HIGH ? rst_oe : !rst_oe;

    always_ff @(posedge clk) begin
        if (rst_act) seen <= 1'b1;
    end

    AST_RESET_LEAVES_END: assert property (@(posedge clk) disable iff (!seen)
        rst_act |=> !end_flag);                                          // R1

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!seen)
        (ce_n && !rst_act && !prog_we) |=> ($stable(data_out) && $stable(end_flag))); // R4

    AST_STANDBY_WHEN_OFF: assert property (@(posedge clk) disable iff (!seen)
        ce_n |-> (standby && !data_en));                                 // R4

    AST_NO_DRIVE_GATED: assert property (@(posedge clk) disable iff (!seen)
        (ce_n || rst_act) |-> !data_en);                                 // R5

    AST_POLARITY_DRIVE: assert property (@(posedge clk) disable iff (!seen)
        (!ce_n && !rst_act) |-> (data_en && !standby));                  // R6

    AST_END_STICKS: assert property (@(posedge clk) disable iff (!seen)
        (end_flag && !rst_act) |=> end_flag);                            // R8

endmodule

bind serprom_read serprom_read_chk #(.RESET_HIGH(RESET_HIGH)) u_chk (.*);

// File: tb/serprom_read_test.sv
`timescale 1ns/1ps
module serprom_read_test;

    localparam int DEPTH = 4096;
    localparam int LAST  = DEPTH - 1;
    localparam int LO_DEPTH = 64;

    typedef struct packed {
        logic        ce_n;
        logic        rst;
        logic [15:0] cycles;
    } step_t;

    // ce_n, logical reset, cycle count
    localparam step_t STEPS [10] = '{
        '{1'b0, 1'b1, 16'd3},
        '{1'b0, 1'b0, 16'd20},
        '{1'b1, 1'b0, 16'd5},
        '{1'b0, 1'b0, 16'd10},
        '{1'b0, 1'b1, 16'd2},
        '{1'b0, 1'b0, 16'd12},
        '{1'b1, 1'b1, 16'd2},
        '{1'b0, 1'b0, 16'd4200},
        '{1'b1, 1'b0, 16'd3},
        '{1'b0, 1'b1, 16'd5}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       ce_n, rst_oe, prog_we;
    logic [8:0] prog_addr;
    logic [7:0] prog_byte;
    logic       data_out, data_en, standby, end_flag;

    logic       lo_ce_n, lo_rst_oe, lo_we;
    logic [2:0] lo_addr;
    logic       lo_dout, lo_en, lo_standby, lo_end;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    serprom_read #(.DEPTH_BITS(DEPTH), .RESET_HIGH(1'b1)) uut (
        .clk(clk), .ce_n(ce_n), .rst_oe(rst_oe), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_byte(prog_byte),
        .data_out(data_out), .data_en(data_en), .standby(standby), .end_flag(end_flag)
    );

    serprom_read #(.DEPTH_BITS(LO_DEPTH), .RESET_HIGH(1'b0)) uut_lo (
        .clk(clk), .ce_n(lo_ce_n), .rst_oe(lo_rst_oe), .prog_we(lo_we),
        .prog_addr(lo_addr), .prog_byte(prog_byte),
        .data_out(lo_dout), .data_en(lo_en), .standby(lo_standby), .end_flag(lo_end)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 2));
    endfunction

    function automatic logic exp_bit(input int p);
        logic [7:0] b;
        b = pat(p >> 3);
        return b[7 - (p & 7)];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int pos;
        ce_n = 1'b0; rst_oe = 1'b1; prog_we = 1'b0; prog_addr = '0; prog_byte = '0;
        lo_ce_n = 1'b0; lo_rst_oe = 1'b0; lo_we = 1'b0; lo_addr = '0;
        repeat (2) @(negedge clk);

        for (int a = 0; a < DEPTH / 8; a++) begin
            prog_we = 1'b1; prog_addr = 9'(a); prog_byte = pat(a);
            lo_we = (a < LO_DEPTH / 8); lo_addr = 3'(a);
            @(negedge clk);
        end
        prog_we = 1'b0; lo_we = 1'b0;
        @(negedge clk);

        // reset state
        chk("R1 reset data_en", data_en, 1'b0);
        chk("R1 reset end_flag", end_flag, 1'b0);
        chk("R4 standby low while enabled", standby, 1'b0);
        chk("R6 low-polarity reset data_en", lo_en, 1'b0);

        // table walk with a bench-side position model
        pos = 0;
        for (int s = 0; s < 10; s++) begin
            for (int c = 0; c < int'(STEPS[s].cycles); c++) begin
                ce_n   = STEPS[s].ce_n;
                rst_oe = STEPS[s].rst;
                #1;
                chk("R5 data_en gating", data_en, !STEPS[s].ce_n && !STEPS[s].rst);
                chk("R4 standby", standby, STEPS[s].ce_n);
                chk("R8 end flag", end_flag, pos == LAST);
                if (data_en) chk("R2/R3 serial bit", data_out, exp_bit(pos));
                if (STEPS[s].rst)        pos = 0;
                else if (!STEPS[s].ce_n && pos != LAST) pos++;
                @(negedge clk);
            end
        end
        ce_n = 1'b0; rst_oe = 1'b0;
        #1;
        chk("R1 first bit after release", data_out, exp_bit(0));
        chk("R1 end low after release", end_flag, 1'b0);

        // inverted polarity instance
        lo_rst_oe = 1'b1; lo_ce_n = 1'b0;
        #1;
        chk("R6 high level enables output", lo_en, 1'b1);
        chk("R3 bit0 of byte0 is msb", lo_dout, exp_bit(0));
        repeat (5) @(negedge clk);
        lo_ce_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 disabled data_en", lo_en, 1'b0);
        chk("R4 disabled standby", lo_standby, 1'b1);
        lo_ce_n = 1'b0;
        #1;
        chk("R7 stream resumes at next bit", lo_dout, exp_bit(5));
        repeat (3) @(negedge clk);
        #1;
        chk("R3 byte boundary bit", lo_dout, exp_bit(8));
        chk("R2 advance count", lo_end, 1'b0);
        repeat (70) @(negedge clk);
        #1;
        chk("R8 end flag raised", lo_end, 1'b1);
        chk("R8 last bit held", lo_dout, exp_bit(LO_DEPTH - 1));
        lo_rst_oe = 1'b0;
        #1;
        chk("R6 low level releases line", lo_en, 1'b0);
        @(negedge clk);
        lo_rst_oe = 1'b1;
        #1;
        chk("R1 low-polarity reset clears end", lo_end, 1'b0);
        chk("R1 low-polarity first bit", lo_dout, exp_bit(0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule